// File: doc/BRIEF.md
# Layered Sprite Pixel Compositor

This block picks the colour of each pixel of a raster display that shows a simple traffic-crossing game. Each cycle it takes the scan coordinates of the pixel being sent, together with the rectangles of every scene object: one player block, two opaque masking bars at the screen sides, a set of vehicles and two background zones (a goal strip and a grass zone). Whatever no object covers is road. It tests every rectangle against the pixel in parallel, resolves overlaps through a fixed layer order and registers the resulting 8-bit red, green and blue values.

The side bars rank above the vehicles, so vehicles that wrap from one side of the play area to the other vanish under the bars instead of being cut off in view. The player ranks above everything and stays visible at all times. Outside the visible 1280 by 1024 area the block sends black and raises a delayed blank flag that lines up with the colour.

Every rectangle port is packed as {x0, x1, y0, y1}, 11 bits per field, with x0 in the most significant bits. Vehicle k sits in bits [k*44 +: 44] of the vehicle bus.

Top module: `sprite_compositor`

## Requirements
- R1: A pixel (x, y) lies inside a rectangle when x0 <= x < x1 and y0 <= y < y1. The left and top edges are inclusive and the right and bottom edges are exclusive.
- R2: A visible pixel inside the player rectangle is output as green (R=00, G=FF, B=00 hex), whatever other objects also cover it.
- R3: A visible pixel inside either side bar and outside the player is output as black (0, 0, 0), even when a vehicle covers it.
- R4: A visible pixel inside any vehicle, outside the player and outside both bars, is output as red (FF, 00, 00).
- R5: A visible pixel that no player, bar or vehicle covers takes the background colour. Inside the goal strip it is yellow (FF, FF, 00). Otherwise, inside the grass zone it is dark green (00, 80, 00). Anywhere else it is road grey (40, 40, 40).
- R6: A pixel with x >= 1280 or y >= 1024 is blank. All three colour outputs are zero and the blank flag is 1, even when objects cover it.
- R7: The colour outputs and the blank flag are registered. They show the result for the coordinates and rectangles that were present at the previous rising clock edge, and they stay unchanged between edges.
- R8: While reset is high and after reset, before the first new pixel is captured, all colour outputs are zero and the blank flag is 1.
- R9: A rectangle with x1 <= x0 or y1 <= y0 is empty and covers no pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_x | input | 11 | Horizontal scan coordinate |
| pix_y | input | 11 | Vertical scan coordinate |
| player_box | input | 44 | Player rectangle {x0,x1,y0,y1} |
| bar_left_box | input | 44 | Left masking bar rectangle |
| bar_right_box | input | 44 | Right masking bar rectangle |
| veh_boxes | input | 264 | Six vehicle rectangles, vehicle k at [k*44 +: 44] |
| goal_box | input | 44 | Goal strip rectangle |
| grass_box | input | 44 | Grass zone rectangle |
| vid_r | output | 8 | Registered red value |
| vid_g | output | 8 | Registered green value |
| vid_b | output | 8 | Registered blue value |
| vid_blank | output | 1 | Registered blank flag, aligned with the colour |

## Verification
Every result of this block (the three colour channels and the blank flag) is due exactly one rising edge after the coordinates and rectangles that produce it. The bench changes inputs on the falling edge, waits one rising edge and compares on the next falling edge. Each check therefore sees the register loaded from exactly the stimulus it predicted. One directed check also samples just after new inputs are applied and before the next edge, to confirm that the previous result is still held. The clocked properties in the RTL state the same one-edge relation with |=>, from the per-object hit signals to the registered colour.

// File: rtl/compositor_pkg.sv
`timescale 1ns/1ps
package compositor_pkg;

    localparam int COORD_W = 11;
    localparam int RECT_W  = 4 * COORD_W;
    localparam int CHAN_W  = 8;

    typedef logic [COORD_W-1:0] coord_t;

    typedef struct packed {
        coord_t x0;
        coord_t x1;
        coord_t y0;
        coord_t y1;
    } rect_t;

    typedef struct packed {
        logic [CHAN_W-1:0] r;
        logic [CHAN_W-1:0] g;
        logic [CHAN_W-1:0] b;
    } rgb_t;

    // Layers, highest priority first.
    typedef enum logic [2:0] {
        LYR_PLAYER = 3'd0,
        LYR_BAR    = 3'd1,
        LYR_VEH    = 3'd2,
        LYR_GOAL   = 3'd3,
        LYR_GRASS  = 3'd4,
        LYR_ROAD   = 3'd5
    } layer_e;

    localparam rgb_t COL_PLAYER = '{r: 8'h00, g: 8'hFF, b: 8'h00};
    localparam rgb_t COL_BAR    = '{r: 8'h00, g: 8'h00, b: 8'h00};
    localparam rgb_t COL_VEH    = '{r: 8'hFF, g: 8'h00, b: 8'h00};
    localparam rgb_t COL_GOAL   = '{r: 8'hFF, g: 8'hFF, b: 8'h00};
    localparam rgb_t COL_GRASS  = '{r: 8'h00, g: 8'h80, b: 8'h00};
    localparam rgb_t COL_ROAD   = '{r: 8'h40, g: 8'h40, b: 8'h40};
    localparam rgb_t COL_DARK   = '{r: 8'h00, g: 8'h00, b: 8'h00};

    // Half-open containment: left/top inclusive, right/bottom exclusive.
    function automatic logic rect_has(rect_t box, coord_t x, coord_t y);
        return (x >= box.x0) && (x < box.x1) && (y >= box.y0) && (y < box.y1);
    endfunction

    function automatic rgb_t layer_colour(layer_e lyr);
        rgb_t c;
        case (lyr)
            LYR_PLAYER: c = COL_PLAYER;
            LYR_BAR:    c = COL_BAR;
            LYR_VEH:    c = COL_VEH;
            LYR_GOAL:   c = COL_GOAL;
            LYR_GRASS:  c = COL_GRASS;
            default:    c = COL_ROAD;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/rect_hit_bank.sv
`timescale 1ns/1ps
module rect_hit_bank
    import compositor_pkg::*;
#(
    parameter int N_BOX = 1
) (
    input  coord_t                  px,
    input  coord_t                  py,
    input  logic [N_BOX*RECT_W-1:0] boxes,
    output logic [N_BOX-1:0]        hit
);

    for (genvar k = 0; k < N_BOX; k++) begin : g_box
        rect_t box_k;
        assign box_k  = rect_t'(boxes[k*RECT_W +: RECT_W]);
        assign hit[k] = rect_has(box_k, px, py);

        // R9
        always_comb begin
            empty_box_chk: assert (!(hit[k] && ((box_k.x1 <= box_k.x0) || (box_k.y1 <= box_k.y0))));
        end
    end

endmodule

// File: rtl/layer_arbiter.sv
`timescale 1ns/1ps
module layer_arbiter
    import compositor_pkg::*;
(
    input  logic   player_hit,
    input  logic   bar_hit,
    input  logic   veh_hit,
    input  logic   goal_hit,
    input  logic   grass_hit,
    output layer_e layer
);

    always_comb begin
        if (player_hit)     layer = LYR_PLAYER;
        else if (bar_hit)   layer = LYR_BAR;
        else if (veh_hit)   layer = LYR_VEH;
        else if (goal_hit)  layer = LYR_GOAL;
        else if (grass_hit) layer = LYR_GRASS;
        else                layer = LYR_ROAD;
    end

    // R2
    always_comb begin
        player_wins_chk: assert (!player_hit || layer == LYR_PLAYER);
    end

endmodule

// File: rtl/sprite_compositor.sv
`timescale 1ns/1ps
module sprite_compositor
    import compositor_pkg::*;
#(
    parameter int N_VEH    = 6,
    parameter int H_ACTIVE = 1280,
    parameter int V_ACTIVE = 1024
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [COORD_W-1:0]      pix_x,
    input  logic [COORD_W-1:0]      pix_y,
    input  logic [RECT_W-1:0]       player_box,
    input  logic [RECT_W-1:0]       bar_left_box,
    input  logic [RECT_W-1:0]       bar_right_box,
    input  logic [N_VEH*RECT_W-1:0] veh_boxes,
    input  logic [RECT_W-1:0]       goal_box,
    input  logic [RECT_W-1:0]       grass_box,
    output logic [CHAN_W-1:0]       vid_r,
    output logic [CHAN_W-1:0]       vid_g,
    output logic [CHAN_W-1:0]       vid_b,
    output logic                    vid_blank
);

    localparam coord_t H_LIM = coord_t'(H_ACTIVE);
    localparam coord_t V_LIM = coord_t'(V_ACTIVE);

    logic             player_hit;
    logic [1:0]       bar_hit;
    logic [N_VEH-1:0] veh_hit;
    logic [1:0]       zone_hit;
    layer_e           layer;
    logic             blank_now;
    rgb_t             colour_next;
    rgb_t             colour_q;

    rect_hit_bank #(.N_BOX(1)) u_player_hit (
        .px(pix_x), .py(pix_y), .boxes(player_box), .hit(player_hit)
    );

    rect_hit_bank #(.N_BOX(2)) u_bar_hit (
        .px(pix_x), .py(pix_y), .boxes({bar_right_box, bar_left_box}), .hit(bar_hit)
    );

    rect_hit_bank #(.N_BOX(N_VEH)) u_veh_hit (
        .px(pix_x), .py(pix_y), .boxes(veh_boxes), .hit(veh_hit)
    );

    // zone_hit[1] = goal, zone_hit[0] = grass
    rect_hit_bank #(.N_BOX(2)) u_zone_hit (
        .px(pix_x), .py(pix_y), .boxes({goal_box, grass_box}), .hit(zone_hit)
    );

    layer_arbiter u_arb (
        .player_hit (player_hit),
        .bar_hit    (|bar_hit),
        .veh_hit    (|veh_hit),
        .goal_hit   (zone_hit[1]),
        .grass_hit  (zone_hit[0]),
        .layer      (layer)
    );

    assign blank_now   = (pix_x >= H_LIM) || (pix_y >= V_LIM);
    assign colour_next = blank_now ? COL_DARK : layer_colour(layer);

    always_ff @(posedge clk) begin
        if (rst) begin
            colour_q  <= COL_DARK;
            vid_blank <= 1'b1;
        end else begin
            colour_q  <= colour_next;
            vid_blank <= blank_now;
        end
    end

    assign vid_r = colour_q.r;
    assign vid_g = colour_q.g;
    assign vid_b = colour_q.b;

    // R2
    player_green_chk: assert property (@(posedge clk) disable iff (rst)
        (player_hit && !blank_now) |=> ({vid_r, vid_g, vid_b} == 24'h00FF00 && !vid_blank));

    // R3
    bar_masks_veh_chk: assert property (@(posedge clk) disable iff (rst)
        ((|bar_hit) && !player_hit && !blank_now) |=> ({vid_r, vid_g, vid_b} == 24'h000000 && !vid_blank));

    // R4
    veh_red_chk: assert property (@(posedge clk) disable iff (rst)
        ((|veh_hit) && !(|bar_hit) && !player_hit && !blank_now) |=> ({vid_r, vid_g, vid_b} == 24'hFF0000));

    // R6
    blank_dark_chk: assert property (@(posedge clk) disable iff (rst)
        vid_blank |-> ({vid_r, vid_g, vid_b} == 24'h000000));

    // R7
    blank_delay_chk: assert property (@(posedge clk) disable iff (rst)
        blank_now |=> vid_blank);

endmodule

// File: tb/sprite_compositor_bench.sv
`timescale 1ns/1ps
module sprite_compositor_bench;

    localparam int CW   = 11;
    localparam int BW   = 44;
    localparam int NV   = 6;
    localparam int NBOX = 11;   // 0 player, 1 left bar, 2 right bar, 3..8 vehicles, 9 goal, 10 grass

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [CW-1:0]   pix_x = '0;
    logic [CW-1:0]   pix_y = '0;
    logic [BW-1:0]   player_box = '0;
    logic [BW-1:0]   bar_left_box = '0;
    logic [BW-1:0]   bar_right_box = '0;
    logic [NV*BW-1:0] veh_boxes = '0;
    logic [BW-1:0]   goal_box = '0;
    logic [BW-1:0]   grass_box = '0;
    logic [7:0]      vid_r, vid_g, vid_b;
    logic            vid_blank;

    int bx0 [NBOX];
    int bx1 [NBOX];
    int by0 [NBOX];
    int by1 [NBOX];

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    sprite_compositor u_sprite_compositor (
        .clk(clk), .rst(rst), .pix_x(pix_x), .pix_y(pix_y),
        .player_box(player_box), .bar_left_box(bar_left_box),
        .bar_right_box(bar_right_box), .veh_boxes(veh_boxes),
        .goal_box(goal_box), .grass_box(grass_box),
        .vid_r(vid_r), .vid_g(vid_g), .vid_b(vid_b), .vid_blank(vid_blank)
    );

    function automatic logic [BW-1:0] pack_box(int idx);
        return {CW'(bx0[idx]), CW'(bx1[idx]), CW'(by0[idx]), CW'(by1[idx])};
    endfunction

    function automatic bit inside_box(int idx, int x, int y);
        return (x >= bx0[idx]) && (x < bx1[idx]) && (y >= by0[idx]) && (y < by1[idx]);
    endfunction

    // Expected {blank, r, g, b} and the requirement it exercises.
    function automatic logic [24:0] ref_pixel(int x, int y, output string tag);
        bit veh = 1'b0;
        for (int k = 3; k < 3 + NV; k++) if (inside_box(k, x, y)) veh = 1'b1;
        if (x >= 1280 || y >= 1024)           begin tag = "R6"; return 25'h1_000000; end
        if (inside_box(0, x, y))              begin tag = "R2"; return 25'h0_00FF00; end
        if (inside_box(1, x, y) || inside_box(2, x, y))
                                              begin tag = "R3"; return 25'h0_000000; end
        if (veh)                              begin tag = "R4"; return 25'h0_FF0000; end
        if (inside_box(9, x, y))              begin tag = "R5"; return 25'h0_FFFF00; end
        if (inside_box(10, x, y))             begin tag = "R5"; return 25'h0_008000; end
        tag = "R5";
        return 25'h0_404040;
    endfunction

    task automatic push_boxes();
        player_box    = pack_box(0);
        bar_left_box  = pack_box(1);
        bar_right_box = pack_box(2);
        for (int k = 0; k < NV; k++) veh_boxes[k*BW +: BW] = pack_box(3 + k);
        goal_box  = pack_box(9);
        grass_box = pack_box(10);
    endtask

    task automatic clear_boxes();
        for (int k = 0; k < NBOX; k++) begin
            bx0[k] = 0; bx1[k] = 0; by0[k] = 0; by1[k] = 0;
        end
    endtask

    task automatic set_box(int idx, int a, int b, int c, int d);
        bx0[idx] = a; bx1[idx] = b; by0[idx] = c; by1[idx] = d;
    endtask

    task automatic compare(logic [24:0] exp, string tag);
        logic [24:0] act;
        act = {vid_blank, vid_r, vid_g, vid_b};
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got blank=%0b rgb=%06h, expected blank=%0b rgb=%06h",
                     tag, act[24], act[23:0], exp[24], exp[23:0]);
        end
    endtask

    // Drive at a falling edge, one rising edge loads, compare at the next falling edge.
    task automatic probe(int x, int y, string tag_in);
        string       tag;
        logic [24:0] exp;
        pix_x = CW'(x);
        pix_y = CW'(y);
        push_boxes();
        exp = ref_pixel(x, y, tag);
        if (tag_in != "") tag = tag_in;
        @(posedge clk);
        @(negedge clk);
        compare(exp, tag);
    endtask

    function automatic int clampc(int v);
        if (v < 0) return 0;
        if (v > 2047) return 2047;
        return v;
    endfunction

    initial begin : watchdog
        #1_500_000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : stimulus
        int unused_seed;
        unused_seed = $urandom(32'd20240611);
        clear_boxes();
        push_boxes();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R8: reset state
        compare(25'h1_000000, "R8");
        rst = 1'b0;
        // R8: still held before first capture after reset
        #1;
        compare(25'h1_000000, "R8");
        @(negedge clk);

        // R1 edges of a lone player rectangle
        clear_boxes();
        set_box(0, 100, 110, 50, 60);
        probe(100,  50, "R1");
        probe(109,  59, "R1");
        probe(110,  50, "R1");
        probe(100,  60, "R1");
        probe( 99,  55, "R1");
        probe(105,  49, "R1");

        // R9 empty rectangles
        clear_boxes();
        set_box(0, 200, 200, 10, 40);
        set_box(3, 220, 210, 10, 40);
        probe(200, 20, "R9");
        probe(215, 20, "R9");

        // R3 bar over vehicle, R4 vehicle visible past the bar, R2 player over bar
        clear_boxes();
        set_box(1, 0, 40, 0, 1024);
        set_box(2, 1240, 1280, 0, 1024);
        set_box(5, 0, 300, 400, 440);
        set_box(8, 1200, 1280, 500, 540);
        probe(  20, 410, "R3");
        probe(1250, 520, "R3");
        probe( 100, 410, "R4");
        probe(1220, 520, "R4");
        set_box(0, 10, 30, 405, 425);
        probe(  20, 410, "R2");

        // R5 background order
        clear_boxes();
        set_box(9, 0, 1280, 0, 64);
        set_box(10, 0, 1280, 32, 128);
        probe(500,  40, "R5");
        probe(500, 100, "R5");
        probe(500, 300, "R5");
        set_box(4, 480, 520, 90, 110);
        probe(500, 100, "R4");

        // R6 blanking edges, player spanning the boundary
        clear_boxes();
        set_box(0, 1270, 1300, 1015, 1040);
        probe(1279, 1020, "R6");
        probe(1280, 1020, "R6");
        probe(1275, 1023, "R6");
        probe(1275, 1024, "R6");
        probe(2047, 2047, "R6");

        // R7 output held until the next edge
        clear_boxes();
        set_box(3, 0, 50, 0, 50);
        probe(10, 10, "R7");
        pix_x = 11'd900;
        pix_y = 11'd900;
        #1;
        compare(25'h0_FF0000, "R7");
        @(posedge clk);
        @(negedge clk);
        compare(25'h0_404040, "R7");

        // Random scenes around the probe point
        for (int t = 0; t < 600; t++) begin
            int x, y;
            x = int'($urandom % 1400);
            y = int'($urandom % 1100);
            for (int k = 0; k < NBOX; k++) begin
                int a, c;
                a = clampc(x - 40 + int'($urandom % 60));
                c = clampc(y - 40 + int'($urandom % 60));
                bx0[k] = a;
                bx1[k] = clampc(a + int'($urandom % 70));
                by0[k] = c;
                by1[k] = clampc(c + int'($urandom % 70));
            end
            probe(x, y, "");
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule